// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. It divides the system clock down to a pixel-rate enable. From that enable it runs a horizontal and a vertical position counter, and it decodes the counters into horizontal sync, vertical sync, data enable, a start-of-frame strobe, and the X/Y coordinates of the visible pixel. Pixel fetch and colour formatting are left to the logic that consumes these outputs.

Software programs the block through a single-cycle write port of eight word addresses. The words hold the lengths of the sync, porch and active segments on both axes, the divider and its clock source, the polarity of the syncs and of the pixel clock, and the set and clear controls of the frame interrupt. Writes land in a shadow copy. The working copy takes the shadow contents only on the edge that ends a frame, so a frame is never built from a mix of old and new settings. The interrupt enable is the one exception and responds at once.

Top module: `lcd_raster_timer`

## Requirements
- R1: Word 1 holds the horizontal sync length minus one in bits 15:0 and the vertical sync length minus one in bits 31:16. Word 2 holds the vertical front porch minus one in bits 15:0 and the vertical back porch as its true count (zero allowed) in bits 31:16. Word 3 holds the horizontal front porch minus one in bits 15:0 and the horizontal back porch minus one in bits 31:16. Word 4 holds the active width minus one in bits 15:0 and the active height minus one in bits 31:16.
- R2: Each line runs sync, back porch, active and front porch, one pixel period per count. hsync_o is asserted during the sync segment.
- R3: Each frame runs the same four segments counted in lines. vsync_o is asserted during the vertical sync lines. A vertical back porch of zero puts the first active line directly after sync.
- R4: de_o is high only when both axes are in their active segments. x_o and y_o then give the offset from the first active pixel and the first active line, and both are 0 whenever de_o is low.
- R5: Word 0 bits 23:16 hold the divider d, where a value below 2 counts as 2. Word 0 bit 0 selects the source: with 0, pce_o pulses once every d system cycles; with 1, a source at twice the system rate is divided, so an even d gives one pulse every d/2 cycles.
- R6: Word 5 bit 0 makes hsync_o active low, and word 5 bit 1 makes vsync_o active low.
- R7: pclk_o is high in the first system cycle of each pixel, which makes its rising edge line up with the change of pixel data. Word 0 bit 1 inverts it, so the data then changes on the falling edge.
- R8: sof_o is high for exactly the first pixel period of every frame, which is the first pixel of the first sync line.
- R9: A write of bit 0 set to word 6 enables the frame interrupt, and a write of bit 0 set to word 7 disables it. irq_o equals sof_o while the interrupt is enabled and stays 0 otherwise. The interrupt is disabled after reset.
- R10: Writes to words 0 to 5 take effect on the edge that ends the current frame, never in the middle of one.
- R11: While reset is held and directly after it is released, the block sits at the first pixel of a frame with the default timing: hsync_o=1, vsync_o=1, de_o=0, sof_o=1, irq_o=0, pce_o=0, pclk_o=0, x_o=y_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pclk_o | output | 1 | Pixel clock with programmable polarity |
| pce_o | output | 1 | Pixel enable; the pixel advances after a cycle in which it is high |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable, high for visible pixels |
| sof_o | output | 1 | Start-of-frame, high for the first pixel of a frame |
| irq_o | output | 1 | Start-of-frame interrupt, gated by the enable |
| x_o | output | 16 | Column of the visible pixel |
| y_o | output | 16 | Row of the visible pixel |

## Verification
The assertions check on every cycle that each position counter stays inside the span its axis is programmed for, that data enable never overlaps either sync, that the start-of-frame strobe ends at the next pixel, that the plain-source divider never pulses on two cycles in a row, and that the working settings change only on a frame-ending edge. The bench scenarios are needed for the end-to-end results. These are the segment order and lengths for several timing sets, including a zero vertical back porch and divider values clamped to 2. The bench also confirms the exact pixel period for each source selection, the polarity of the syncs and of the pixel clock, and the gating of the interrupt. Finally, it shows that a mid-frame write leaves the running frame at its old length and sets the length of the next one.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    localparam int FIELD_W  = 16;
    localparam int HALF_LSB = 16;
    localparam int DIV_W    = 8;
    localparam int DIV_LSB  = 16;
    localparam int SPAN_W   = FIELD_W + 3;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [SPAN_W-1:0]  span_t;
    typedef logic [DIV_W-1:0]   div_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CLK     = 3'd0,
        A_SYNC    = 3'd1,
        A_VPORCH  = 3'd2,
        A_HPORCH  = 3'd3,
        A_ACTIVE  = 3'd4,
        A_POL     = 3'd5,
        A_IRQ_ON  = 3'd6,
        A_IRQ_OFF = 3'd7
    } reg_addr_e;

    typedef struct packed {
        field_t hsw_m1;
        field_t hbp_m1;
        field_t hact_m1;
        field_t hfp_m1;
        field_t vsw_m1;
        field_t vbp;
        field_t vact_m1;
        field_t vfp_m1;
    } raster_cfg_t;

    typedef struct packed {
        logic src2;
        logic pclk_inv;
        div_t div;
    } clk_cfg_t;

    typedef struct packed {
        logic hs_low;
        logic vs_low;
    } pol_cfg_t;

    typedef struct packed {
        raster_cfg_t r;
        clk_cfg_t    c;
        pol_cfg_t    p;
    } lcd_cfg_t;

    typedef struct packed {
        span_t sync_end;
        span_t act_start;
        span_t act_end;
        span_t total;
    } span_set_t;

    localparam lcd_cfg_t CFG_RESET = '{
        r: '{hsw_m1: 16'd0, hbp_m1: 16'd0, hact_m1: 16'd3, hfp_m1: 16'd0,
             vsw_m1: 16'd0, vbp: 16'd1, vact_m1: 16'd1, vfp_m1: 16'd0},
        c: '{src2: 1'b0, pclk_inv: 1'b0, div: 8'd2},
        p: '{hs_low: 1'b0, vs_low: 1'b0}
    };

    function automatic span_t seg_len(input field_t m1);
        return span_t'(m1) + span_t'(1);
    endfunction

    function automatic span_set_t h_spans(input raster_cfg_t c);
        span_set_t s;
        s.sync_end  = seg_len(c.hsw_m1);
        s.act_start = s.sync_end + seg_len(c.hbp_m1);
        s.act_end   = s.act_start + seg_len(c.hact_m1);
        s.total     = s.act_end + seg_len(c.hfp_m1);
        return s;
    endfunction

    function automatic span_set_t v_spans(input raster_cfg_t c);
        span_set_t s;
        s.sync_end  = seg_len(c.vsw_m1);
        s.act_start = s.sync_end + span_t'(c.vbp);
        s.act_end   = s.act_start + seg_len(c.vact_m1);
        s.total     = s.act_end + seg_len(c.vfp_m1);
        return s;
    endfunction

    function automatic div_t eff_div(input div_t d);
        if (d < div_t'(2)) begin
            return div_t'(2);
        end
        return d;
    endfunction

endpackage

// File: rtl/lcd_cfg_bank.sv
module lcd_cfg_bank
    import lcd_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output lcd_cfg_t          active,
    output logic              irq_en
);

    lcd_cfg_t shadow;
    field_t   lo_half;
    field_t   hi_half;

    always_comb begin
        lo_half = wr_data[FIELD_W-1:0];
        hi_half = wr_data[HALF_LSB +: FIELD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= CFG_RESET;
            active <= CFG_RESET;
            irq_en <= 1'b0;
        end else begin
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    A_CLK: begin
                        shadow.c.src2     <= wr_data[0];
                        shadow.c.pclk_inv <= wr_data[1];
                        shadow.c.div      <= wr_data[DIV_LSB +: DIV_W];
                    end
                    A_SYNC: begin
                        shadow.r.hsw_m1 <= lo_half;
                        shadow.r.vsw_m1 <= hi_half;
                    end
                    A_VPORCH: begin
                        shadow.r.vfp_m1 <= lo_half;
                        shadow.r.vbp    <= hi_half;
                    end
                    A_HPORCH: begin
                        shadow.r.hfp_m1 <= lo_half;
                        shadow.r.hbp_m1 <= hi_half;
                    end
                    A_ACTIVE: begin
                        shadow.r.hact_m1 <= lo_half;
                        shadow.r.vact_m1 <= hi_half;
                    end
                    A_POL: begin
                        shadow.p.hs_low <= wr_data[0];
                        shadow.p.vs_low <= wr_data[1];
                    end
                    A_IRQ_ON: begin
                        if (wr_data[0]) irq_en <= 1'b1;
                    end
                    A_IRQ_OFF: begin
                        if (wr_data[0]) irq_en <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (load) begin
                active <= shadow;
            end
        end
    end

    // R10: the working settings move only on a frame-ending edge
    a_r10_hold_mid_frame: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));

endmodule

// File: rtl/lcd_pix_div.sv
module lcd_pix_div
    import lcd_timing_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  clk_cfg_t cfg,
    output logic     pce,
    output logic     pclk_raw
);

    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] nxt;
    logic [ACC_W-1:0] dfull;
    logic [1:0]       step;
    logic             fire;

    always_comb begin
        step  = cfg.src2 ? 2'd2 : 2'd1;
        dfull = ACC_W'(eff_div(cfg.div));
        nxt   = acc + ACC_W'(step);
        fire  = (nxt >= dfull);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            pce      <= 1'b0;
            pclk_raw <= 1'b0;
        end else begin
            if (load) begin
                acc <= '0;
            end else if (fire) begin
                acc <= nxt - dfull;
            end else begin
                acc <= nxt;
            end
            pce      <= fire;
            pclk_raw <= pce;
        end
    end

    // R5: with the plain source the divide ratio is at least 2
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (!cfg.src2 && !$past(cfg.src2) && pce) |=> !pce);

endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt
    import lcd_timing_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  span_set_t span,
    output logic      last,
    output logic      first,
    output logic      in_sync,
    output logic      in_act,
    output field_t    pos
);

    span_t cnt;

    always_comb begin
        last    = (cnt == span.total - span_t'(1));
        first   = (cnt == '0);
        in_sync = (cnt < span.sync_end);
        in_act  = (cnt >= span.act_start) && (cnt < span.act_end);
        pos     = in_act ? field_t'(cnt - span.act_start) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt + span_t'(1);
        end
    end

    // R2: the position never leaves the programmed span
    a_r2_within_span: assert property (@(posedge clk) disable iff (rst)
        cnt < span.total);

    // R3: every span starts with its sync segment
    a_r3_sync_leads: assert property (@(posedge clk) disable iff (rst)
        first |-> in_sync);

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pclk_o,
    output logic              pce_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              sof_o,
    output logic              irq_o,
    output field_t            x_o,
    output field_t            y_o
);

    lcd_cfg_t  act;
    logic      irq_en;
    logic      pce;
    logic      pclk_raw;
    logic      frame_end;
    span_set_t hsp;
    span_set_t vsp;
    logic      h_last, h_first, h_sync, h_act;
    logic      v_last, v_first, v_sync, v_act;
    field_t    h_pos, v_pos;

    always_comb begin
        hsp       = h_spans(act.r);
        vsp       = v_spans(act.r);
        frame_end = pce && h_last && v_last;
    end

    lcd_cfg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (frame_end),
        .active  (act),
        .irq_en  (irq_en)
    );

    lcd_pix_div u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_end),
        .cfg      (act.c),
        .pce      (pce),
        .pclk_raw (pclk_raw)
    );

    lcd_axis_cnt u_hcnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (pce),
        .span    (hsp),
        .last    (h_last),
        .first   (h_first),
        .in_sync (h_sync),
        .in_act  (h_act),
        .pos     (h_pos)
    );

    lcd_axis_cnt u_vcnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (pce && h_last),
        .span    (vsp),
        .last    (v_last),
        .first   (v_first),
        .in_sync (v_sync),
        .in_act  (v_act),
        .pos     (v_pos)
    );

    always_comb begin
        de_o    = h_act && v_act;
        x_o     = de_o ? h_pos : '0;
        y_o     = de_o ? v_pos : '0;
        hsync_o = h_sync ^ act.p.hs_low;
        vsync_o = v_sync ^ act.p.vs_low;
        pclk_o  = pclk_raw ^ act.c.pclk_inv;
        pce_o   = pce;
        sof_o   = h_first && v_first;
        irq_o   = sof_o && irq_en;
    end

    // R4: visible pixels never fall inside either sync
    a_r4_de_clear_of_sync: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (!h_sync && !v_sync));

    // R8: the frame strobe covers a single pixel period
    a_r8_sof_one_pixel: assert property (@(posedge clk) disable iff (rst)
        (sof_o && pce_o) |=> !sof_o);

endmodule

// File: tb/lcd_raster_timer_tb.sv
`timescale 1ns/1ps
module lcd_raster_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pclk_o, pce_o, hsync_o, vsync_o, de_o, sof_o, irq_o;
    logic [15:0] x_o, y_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_raster_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pclk_o(pclk_o), .pce_o(pce_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .sof_o(sof_o), .irq_o(irq_o), .x_o(x_o), .y_o(y_o)
    );

    typedef struct packed {
        int hsw; int hbp; int hact; int hfp;
        int vsw; int vbp; int vact; int vfp;
        int div; int src2; int hpol; int vpol; int cpol;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1, 1, 4, 1,  1, 1, 2, 1,  2, 0, 0, 0, 0},
        '{2, 3, 5, 2,  2, 0, 3, 1,  3, 0, 1, 0, 1},
        '{1, 2, 3, 1,  1, 2, 2, 2,  4, 1, 0, 1, 0},
        '{3, 1, 2, 3,  1, 1, 1, 1,  0, 0, 1, 1, 1},
        '{1, 1, 3, 1,  1, 3, 2, 1,  1, 1, 0, 0, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 32'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // R1: field packing of words 0..5
    task automatic write_cfg(input vec_t v);
        wr(0, (v.div << 16) | (v.cpol << 1) | v.src2);
        wr(1, (v.hsw - 1) | ((v.vsw - 1) << 16));
        wr(2, (v.vfp - 1) | (v.vbp << 16));
        wr(3, (v.hfp - 1) | ((v.hbp - 1) << 16));
        wr(4, (v.hact - 1) | ((v.vact - 1) << 16));
        wr(5, (v.vpol << 1) | v.hpol);
    endtask

    task automatic wait_sof_rise(output int n);
        n = 0;
        while (sof_o) begin @(negedge clk); n++; end
        while (!sof_o) begin @(negedge clk); n++; end
    endtask

    task automatic walk(input vec_t v, input int idx);
        int htot = v.hsw + v.hbp + v.hact + v.hfp;
        int vtot = v.vsw + v.vbp + v.vact + v.vfp;
        int has  = v.hsw + v.hbp;
        int vas  = v.vsw + v.vbp;
        int d    = (v.div < 2) ? 2 : v.div;
        int per  = (v.src2 != 0) ? d / 2 : d;
        int e_h = 0, e_v = 0, e_d = 0, e_x = 0, e_p = 0, e_c = 0, e_s = 0;
        for (int p = 0; p < htot * vtot; p++) begin
            int  h  = p % htot;
            int  vv = p / htot;
            int  n  = 0;
            bit  pc;
            bit  de_e = (h >= has) && (h < has + v.hact) && (vv >= vas) && (vv < vas + v.vact);
            int  xe = de_e ? h - has : 0;
            int  ye = de_e ? vv - vas : 0;
            bit  hs_e = (h < v.hsw) ^ (v.hpol != 0);
            bit  vs_e = (vv < v.vsw) ^ (v.vpol != 0);
            if (hsync_o !== hs_e) e_h++;
            if (vsync_o !== vs_e) e_v++;
            if (de_o !== de_e) e_d++;
            if (int'(x_o) != xe || int'(y_o) != ye) e_x++;
            if (sof_o !== (p == 0)) e_s++;
            if (pclk_o !== (1'b1 ^ (v.cpol != 0))) e_c++;
            do begin
                pc = pce_o;
                @(negedge clk);
                n++;
            end while (!pc);
            if (p > 0 && n != per) e_p++;
        end
        $display("vector %0d: mismatches h=%0d v=%0d de=%0d xy=%0d per=%0d pclk=%0d sof=%0d",
                 idx, e_h, e_v, e_d, e_x, e_p, e_c, e_s);
        check("R2 R6 hsync segments and polarity", e_h, 0);
        check("R3 R6 vsync segments and polarity", e_v, 0);
        check("R4 data enable", e_d, 0);
        check("R4 coordinates", e_x, 0);
        check("R5 pixel period", e_p, 0);
        check("R7 pixel clock phase", e_c, 0);
        check("R8 start of frame", e_s, 0);
    endtask

    initial begin
        int n, n2;
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 hsync", int'(hsync_o), 1);
        check("R11 vsync", int'(vsync_o), 1);
        check("R11 de", int'(de_o), 0);
        check("R11 sof", int'(sof_o), 1);
        check("R11 pce", int'(pce_o), 0);
        rst = 1'b0;
        check("R11 after release hsync", int'(hsync_o), 1);
        check("R11 after release sof", int'(sof_o), 1);
        check("R11 after release pclk", int'(pclk_o), 0);
        check("R11 after release xy", int'(x_o) + int'(y_o), 0);
        check("R9 irq off after reset", int'(irq_o), 0);

        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i]);
            wait_sof_rise(n);
            walk(VECS[i], i);
        end

        // R9: interrupt gating, now at the first pixel of a frame
        check("R9 irq disabled during sof", int'(irq_o), 0);
        wr(6, 1);
        wait_sof_rise(n);
        check("R9 irq enabled during sof", int'(irq_o), 1);
        @(negedge clk);
        @(negedge clk);
        check("R9 irq low outside sof", int'(irq_o), 0);
        wr(7, 1);
        wait_sof_rise(n);
        check("R9 irq disabled again", int'(irq_o), 0);

        // R10: mid-frame write keeps this frame at 6x7 pixels, next is 9x7
        repeat (3) @(negedge clk);
        wr(4, (6 - 1) | ((2 - 1) << 16));
        wait_sof_rise(n);
        check("R10 running frame length unchanged", n + 5, 42);
        wait_sof_rise(n2);
        check("R10 next frame uses new width", n2, 63);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule